// File: doc/BRIEF.md
# External DMA Request Front-End

This block sits between an off-chip DMA request pin and the transfer engine of one DMA channel. It brings the asynchronous pin into the bus clock domain, which runs at half the core rate. It then decides whether the pin carries a new request and hands the engine a one-cycle request strobe. A pending flag shows a request that has been seen but that the engine has not yet started.

A mode input selects the detection style. In edge mode a rising edge on the synchronised pin counts as a request. An edge that arrives while the channel cannot take a request is held as pending until it can. In level mode the pin must stay high. If it falls before the engine starts the transfer, the request is withdrawn.

After each transfer start, the channel refuses new requests until the engine's acknowledge lead indication reopens the window. That indication is a two-bit vector: bit 0 means acknowledge follows in one bus cycle, and bit 1 means it follows in two. Edge mode reopens on bit 0 and level mode reopens on bit 1. The engine and the arbitration between channels are outside this block.

Top module: `ext_dma_req_frontend`

## Requirements
- R1: The pin passes two synchronising flops. With the window open and no request outstanding, a pin rise driven before clock edge k gives reqStrobe and reqPending high after edge k+2, and both are low after edge k+1.
- R2: In edge mode a rising edge of the synchronised pin sets reqPending. reqPending then stays high until xferStart, even if the pin falls again.
- R3: In edge mode a closed window reopens only in a cycle with ackLead bit 0 high. ackLead bit 1 alone does not reopen it.
- R4: In level mode a closed window reopens only in a cycle with ackLead bit 1 high. ackLead bit 0 alone does not reopen it.
- R5: In level mode reqPending follows the synchronised pin. A pin that falls before the transfer starts clears reqPending and produces no strobe.
- R6: reqStrobe is high for exactly one bus cycle per accepted request. After it fires, no further strobe is issued until xferStart has been seen.
- R7: xferStart clears reqPending and closes the window. A synchronised rising edge in the same cycle as xferStart in edge mode leaves reqPending set, so the new request is kept.
- R8: A synchronous reset clears reqStrobe, reqPending and the edge history. After reset the window is open.
- R9: reqStrobe is never high in the cycle right after xferStart, and a strobe is issued only from an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, half the core rate |
| rst | input | 1 | Synchronous reset, active high |
| reqPin | input | 1 | Asynchronous request pin from the peripheral |
| levelMode | input | 1 | 1 = level-sensitive, 0 = edge-triggered |
| xferStart | input | 1 | Engine pulse: the requested transfer has started |
| ackLead | input | 2 | Bit 0: acknowledge in one cycle; bit 1: acknowledge in two cycles |
| reqStrobe | output | 1 | One-cycle request strobe to the engine |
| reqPending | output | 1 | Request seen and not yet started |

## Verification
The transfer start and the arrival of a fresh synchronised edge can land in the same cycle. One clears the pending flag and the other sets it. The bench produces this collision by raising the pin exactly two cycles before an xferStart pulse. It expects reqPending to stay high, and no strobe in the following cycle. The collision also occurs often in the random phases, where a cycle model built from the requirements judges every cycle. A second overlap is a window-opening ackLead bit arriving together with xferStart. There the window must stay closed.

// File: rtl/extreq_pkg.sv
package extreq_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic fire;     // issue one request strobe next cycle
    logic clrPend;  // transfer started: drop the pending request
  } ctlStrb_t;
endpackage

// File: rtl/extreq_dp.sv
module extreq_dp
  import extreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqPin,
  input  logic     levelMode,
  input  ctlStrb_t strb,
  output logic     reqSync,
  output logic     reqEdge,
  output logic     reqPending,
  output logic     reqStrobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          pendQ;
  logic          pendNext;
  logic          strobeQ;

  // Synchroniser chain, reset along with the edge history.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[LAST-1:0], reqPin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= reqPin;
      end
    end
  endgenerate

  assign reqSync = syncQ[LAST];

  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= reqSync;
  end

  assign reqEdge = reqSync & ~prevQ;

  // Pending: latched edge in edge mode, held level in level mode.
  always_comb begin
    if (levelMode) pendNext = reqSync & ~strb.clrPend;
    else           pendNext = reqEdge | (pendQ & ~strb.clrPend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      pendQ   <= pendNext;
      strobeQ <= strb.fire;
    end
  end

  assign reqPending = pendQ;
  assign reqStrobe  = strobeQ;
endmodule

// File: rtl/extreq_ctl.sv
module extreq_ctl
  import extreq_pkg::*;
#(
  parameter int LEAD_W     = 2,
  parameter int EDGE_LEAD  = 1,
  parameter int LEVEL_LEAD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              levelMode,
  input  logic              xferStart,
  input  logic [LEAD_W-1:0] ackLead,
  input  logic              reqSync,
  input  logic              reqEdge,
  input  logic              reqPending,
  output ctlStrb_t          strb,
  output logic              windowOpen
);
  localparam int EDGE_IDX  = EDGE_LEAD - 1;
  localparam int LEVEL_IDX = LEVEL_LEAD - 1;

  logic openQ;
  logic issuedQ;
  logic openNow;
  logic haveReq;
  logic fire;

  // Window reopens at the lead distance that suits the mode.
  assign openNow = levelMode ? ackLead[LEVEL_IDX] : ackLead[EDGE_IDX];
  assign haveReq = levelMode ? reqSync : (reqPending | reqEdge);
  assign fire    = openQ & ~issuedQ & ~xferStart & haveReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      openQ   <= 1'b1;
      issuedQ <= 1'b0;
    end else if (xferStart) begin
      openQ   <= 1'b0;
      issuedQ <= 1'b0;
    end else begin
      openQ   <= openQ | openNow;
      issuedQ <= issuedQ | fire;
    end
  end

  assign strb.fire    = fire;
  assign strb.clrPend = xferStart;
  assign windowOpen   = openQ;
endmodule

// File: rtl/ext_dma_req_frontend.sv
module ext_dma_req_frontend
  import extreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_W      = 2,
  parameter int EDGE_LEAD   = 1,
  parameter int LEVEL_LEAD  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqPin,
  input  logic              levelMode,
  input  logic              xferStart,
  input  logic [LEAD_W-1:0] ackLead,
  output logic              reqStrobe,
  output logic              reqPending
);
  ctlStrb_t strb;
  logic     reqSync;
  logic     reqEdge;
  logic     windowOpen;

  extreq_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .reqPin     (reqPin),
    .levelMode  (levelMode),
    .strb       (strb),
    .reqSync    (reqSync),
    .reqEdge    (reqEdge),
    .reqPending (reqPending),
    .reqStrobe  (reqStrobe)
  );

  extreq_ctl #(
    .LEAD_W    (LEAD_W),
    .EDGE_LEAD (EDGE_LEAD),
    .LEVEL_LEAD(LEVEL_LEAD)
  ) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .levelMode  (levelMode),
    .xferStart  (xferStart),
    .ackLead    (ackLead),
    .reqSync    (reqSync),
    .reqEdge    (reqEdge),
    .reqPending (reqPending),
    .strb       (strb),
    .windowOpen (windowOpen)
  );
endmodule

// File: rtl/extreq_chk.sv
module extreq_chk (
  input logic clk,
  input logic rst,
  input logic levelMode,
  input logic xferStart,
  input logic reqSync,
  input logic reqEdge,
  input logic windowOpen,
  input logic reqStrobe,
  input logic reqPending
);
  // R6: strobe lasts a single cycle
  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    reqStrobe |=> !reqStrobe);

  // R9: no strobe right after a transfer start
  assert_quiet_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    xferStart |=> !reqStrobe);

  // R9: a strobe comes only from an open window
  assert_strobe_from_window_R9: assert property (@(posedge clk) disable iff (rst)
    (!windowOpen || xferStart) |=> !reqStrobe);

  // R5: in level mode a low synchronised pin drops the pending flag
  assert_level_withdraw_R5: assert property (@(posedge clk) disable iff (rst)
    (levelMode && !reqSync) |=> !reqPending);

  // R2: in edge mode a pending request is held until the transfer starts
  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!levelMode && !xferStart && reqPending) |=> reqPending);

  // R7: an edge that collides with a transfer start is kept
  assert_collision_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (!levelMode && reqEdge && xferStart) |=> reqPending);

  // R7: transfer start closes the window
  assert_start_closes_R7: assert property (@(posedge clk) disable iff (rst)
    xferStart |=> !windowOpen);
endmodule

bind ext_dma_req_frontend extreq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .levelMode  (levelMode),
  .xferStart  (xferStart),
  .reqSync    (reqSync),
  .reqEdge    (reqEdge),
  .windowOpen (windowOpen),
  .reqStrobe  (reqStrobe),
  .reqPending (reqPending)
);

// File: tb/ext_dma_req_frontend_tb.sv
module ext_dma_req_frontend_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqPin = 1'b0;
  logic       levelMode = 1'b0;
  logic       xferStart = 1'b0;
  logic [1:0] ackLead = 2'b00;
  logic       reqStrobe;
  logic       reqPending;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference state, kept from the requirements.
  logic ms1, ms2, mprev, mpend, miss, macc, mstb;

  always #2 clk = ~clk;  // 250 MHz

  ext_dma_req_frontend dut_i (
    .clk(clk), .rst(rst), .reqPin(reqPin), .levelMode(levelMode),
    .xferStart(xferStart), .ackLead(ackLead),
    .reqStrobe(reqStrobe), .reqPending(reqPending)
  );

  function automatic void mdlStep();
    logic edgeSeen, fire;
    if (rst) begin
      ms1 = 0; ms2 = 0; mprev = 0; mpend = 0; miss = 0; macc = 1; mstb = 0;
      return;
    end
    edgeSeen = ms2 & ~mprev;
    fire = macc & ~miss & ~xferStart & (levelMode ? ms2 : (mpend | edgeSeen));
    if (levelMode) mpend = ms2 & ~xferStart;
    else           mpend = edgeSeen | (mpend & ~xferStart);
    if (xferStart) begin macc = 0; miss = 0; end
    else begin
      macc = macc | (levelMode ? ackLead[1] : ackLead[0]);
      miss = miss | fire;
    end
    mstb = fire;
    mprev = ms2; ms2 = ms1; ms1 = reqPin;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    mdlStep();
    @(posedge clk);
    @(negedge clk);
    chk(tag, reqStrobe, mstb, "reqStrobe");
    chk(tag, reqPending, mpend, "reqPending");
  endtask

  task automatic doReset(input logic lvl);
    rst = 1; levelMode = lvl; reqPin = 0; xferStart = 0; ackLead = 0;
    cyc("R8");
    cyc("R8");
    rst = 0;
    chk("R8", reqStrobe, 1'b0, "reqStrobe after reset");
    chk("R8", reqPending, 1'b0, "reqPending after reset");
  endtask

  initial begin
    #700000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);

    // ---- edge mode directed ----
    doReset(1'b0);
    reqPin = 1;
    cyc("R1");
    chk("R1", reqStrobe, 1'b0, "strobe after one edge");
    cyc("R1");
    chk("R1", reqStrobe, 1'b0, "strobe after two edges");
    cyc("R1");
    chk("R1", reqStrobe, 1'b1, "strobe after three edges");
    chk("R1", reqPending, 1'b1, "pending after three edges");
    cyc("R6");
    chk("R6", reqStrobe, 1'b0, "strobe second cycle");
    reqPin = 0; cyc("R6"); cyc("R6");
    reqPin = 1; repeat (4) cyc("R6");  // second edge, no xferStart: no new strobe
    chk("R2", reqPending, 1'b1, "pending held");
    xferStart = 1; cyc("R7"); xferStart = 0;
    chk("R9", reqStrobe, 1'b0, "strobe after start");
    cyc("R7");
    chk("R7", reqPending, 1'b0, "pending cleared by start");
    reqPin = 0; repeat (3) cyc("R2");
    reqPin = 1; repeat (3) cyc("R2");
    reqPin = 0; repeat (3) cyc("R2");
    chk("R2", reqPending, 1'b1, "edge latched while closed");
    ackLead = 2'b10; cyc("R3"); ackLead = 0; repeat (3) cyc("R3");
    chk("R3", reqStrobe, 1'b0, "bit1 must not reopen edge mode");
    ackLead = 2'b01; cyc("R3"); ackLead = 0;
    cyc("R3");
    chk("R3", reqStrobe, 1'b1, "strobe after bit0 reopen");
    // collision: pin rises two cycles before xferStart
    xferStart = 1; cyc("R7"); xferStart = 0; cyc("R7");
    reqPin = 1; cyc("R7"); cyc("R7");
    xferStart = 1; cyc("R7"); xferStart = 0;
    chk("R7", reqPending, 1'b1, "edge kept on collision");
    chk("R9", reqStrobe, 1'b0, "no strobe on collision");
    // window bit together with xferStart: stays closed
    ackLead = 2'b01; xferStart = 1; cyc("R7"); ackLead = 0; xferStart = 0;
    repeat (3) cyc("R7");
    chk("R7", reqStrobe, 1'b0, "window stays closed");

    for (int i = 0; i < 4000; i++) begin
      reqPin = ($urandom_range(0, 5) == 0) ? ~reqPin : reqPin;
      xferStart = ($urandom_range(0, 9) == 0);
      ackLead = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      cyc("R2");
    end

    // ---- level mode directed ----
    doReset(1'b1);
    xferStart = 1; cyc("R7"); xferStart = 0;
    reqPin = 1; repeat (3) cyc("R5");
    chk("R5", reqPending, 1'b1, "level pending");
    chk("R4", reqStrobe, 1'b0, "closed window level");
    ackLead = 2'b01; cyc("R4"); ackLead = 0; repeat (3) cyc("R4");
    chk("R4", reqStrobe, 1'b0, "bit0 must not reopen level mode");
    reqPin = 0; repeat (3) cyc("R5");
    chk("R5", reqPending, 1'b0, "withdrawn level request");
    ackLead = 2'b10; cyc("R4"); ackLead = 0; repeat (4) cyc("R5");
    chk("R5", reqStrobe, 1'b0, "no strobe for withdrawn request");
    reqPin = 1; cyc("R4"); cyc("R4"); cyc("R4");
    chk("R4", reqStrobe, 1'b1, "strobe after bit1 reopen");
    repeat (3) cyc("R6");
    chk("R6", reqStrobe, 1'b0, "single strobe for held level");

    for (int i = 0; i < 4000; i++) begin
      reqPin = ($urandom_range(0, 5) == 0) ? ~reqPin : reqPin;
      xferStart = ($urandom_range(0, 9) == 0);
      ackLead = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
      cyc("R5");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule